// File: doc/BRIEF.md
# Tournament Chooser with Cascaded History Input

This block merges two predictions of whether an instruction will rewrite its destination register with the value already held there. One prediction comes from a global-history perceptron and the other from a per-instruction local counter predictor. Both component predictors sit outside the block. A table of 2-bit saturating chooser counters, indexed by the low bits of the lookup PC, decides which of the two predictions becomes the final answer.

In cascade mode the block also builds the history vector that feeds the perceptron. The oldest global history bit is dropped, and the local predictor's current output bit takes its place. The combined mode does both at once: the same local bit feeds the cascade input and serves as the selector's alternative.

When an instruction commits, the pipeline returns three things. These are the chooser index captured at lookup, the two predictions that were made at that lookup, and the real outcome. The chooser counter then moves only when exactly one side predicted "redundant" and was correct.

Top module: `tsel_hybrid`

## Requirements
- R1: After synchronous active-low reset, every chooser counter holds 2. In tournament mode, a lookup at any index then returns the perceptron prediction.
- R2: In tournament mode, a counter value of 2 or 3 gives `final_pred_o = glb_pred_i`, and a value of 0 or 1 gives `final_pred_o = loc_pred_i`.
- R3: A valid update with perceptron prediction 1, local prediction 0 and outcome 1 increments the addressed counter.
- R4: A valid update with local prediction 1, perceptron prediction 0 and outcome 1 decrements the addressed counter.
- R5: A valid update leaves the counter unchanged in two cases: both predictions are 1 with outcome 1, or no side predicted 1 and was right (for example, outcome 0).
- R6: Counters saturate. An increment at 3 stays at 3, and a decrement at 0 stays at 0.
- R7: The lookup index is `lk_pc_i[IDX_W-1:0]` and is driven on `lk_idx_o`. Higher PC bits do not affect the selection.
- R8: An update writes only the entry named by `up_idx_i`. A counter changes only on a cycle with `up_valid_i` high, and fields presented with `up_valid_i` low have no effect.
- R9: When `mode_i[1]` is 1 (cascade), `pcp_hist_o` equals `ghist_i` with its oldest bit, bit `HIST_W-1`, replaced by `loc_pred_i`.
- R10: When `mode_i[1]` is 0, `pcp_hist_o` equals `ghist_i`.
- R11: `mode_i[0]` enables selection. When it is 0, `final_pred_o = glb_pred_i`. The encodings are 2'b00 perceptron only, 2'b01 tournament, 2'b10 cascade, and 2'b11 tournament plus cascade.
- R12: Counter training is independent of `mode_i`.
- R13: A lookup in the same cycle as an update to the same entry sees the old counter value. The new value is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Bit 0 enables selection, bit 1 enables cascade |
| lk_pc_i | input | PC_W | Lookup PC |
| ghist_i | input | HIST_W | Global redundancy history, MSB oldest |
| glb_pred_i | input | 1 | Perceptron prediction (1 = redundant) |
| loc_pred_i | input | 1 | Local counter predictor prediction |
| final_pred_o | output | 1 | Selected prediction |
| pcp_hist_o | output | HIST_W | History vector for the perceptron |
| lk_idx_o | output | IDX_W | Chooser index captured at lookup |
| up_valid_i | input | 1 | Commit-time update strobe |
| up_idx_i | input | IDX_W | Chooser index returned at commit |
| up_glb_pred_i | input | 1 | Stored perceptron prediction |
| up_loc_pred_i | input | 1 | Stored local prediction |
| up_actual_i | input | 1 | Real outcome (1 = redundant) |

## Verification
The bench builds the block with an 8-bit PC, a 3-bit index (eight chooser entries) and an 8-bit history. With eight entries, PC aliasing can be exercised from nearby addresses, and the reset check can sweep every counter. A short run of updates is enough to drive one counter through both saturation limits. Same-cycle update and lookup on one entry, updates aimed at a different entry than the one being read, and all four mode encodings are each reached within a few cycles.

// File: rtl/tsel_pkg.sv
// Package: shared types and helpers for the tournament chooser.
// Assumes 2-bit chooser counters; selection threshold is the counter MSB.
package tsel_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'd2;
    localparam ctr_t CTR_MAX  = 2'd3;
    localparam ctr_t CTR_MIN  = 2'd0;

    localparam int MODE_SEL_BIT  = 0;
    localparam int MODE_CASC_BIT = 1;

    // Saturating step of a chooser counter.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic inc, input logic dec);
        ctr_t nxt;
        nxt = cur;
        if (inc && !dec && cur != CTR_MAX) nxt = cur + 2'd1;
        if (dec && !inc && cur != CTR_MIN) nxt = cur - 2'd1;
        return nxt;
    endfunction

    // Counter value favours the perceptron when its upper half is reached.
    function automatic logic prefers_glb(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/tsel_train.sv
// Module: decides the direction of a chooser update from commit data.
// Assumes the stored predictions match the ones that were used at lookup.
module tsel_train (
    input  logic up_glb_pred_i,
    input  logic up_loc_pred_i,
    input  logic up_actual_i,
    output logic inc_o,
    output logic dec_o
);

    logic glb_hit;
    logic loc_hit;

    // Credit each side only for a correct "redundant" call; ties cancel.
    always_comb begin
        glb_hit = up_glb_pred_i && up_actual_i;
        loc_hit = up_loc_pred_i && up_actual_i;
        inc_o   = glb_hit && !loc_hit;
        dec_o   = loc_hit && !glb_hit;
    end

endmodule

// File: rtl/tsel_chooser_table.sv
// Module: array of 2-bit saturating chooser counters with one write port
// and one combinational read port. Assumes synchronous active-low reset;
// a read in the same cycle as a write to that entry returns the old value.
module tsel_chooser_table
    import tsel_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic             inc_i,
    input  logic             dec_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ctr_t             rd_ctr_o
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ctr_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        ctr_t cnt_q;
        logic hit;

        assign hit = wr_en_i && (wr_idx_i == IDX_W'(g));

        // Hold, reset to weak-perceptron, or step on an addressed update.
        always_ff @(posedge clk) begin
            if (!rst_n)   cnt_q <= CTR_INIT;
            else if (hit) cnt_q <= ctr_step(cnt_q, inc_i, dec_i);
        end

        assign ctr_arr[g] = cnt_q;
    end

    assign rd_ctr_o = ctr_arr[rd_idx_i];

endmodule

// File: rtl/tsel_hist_mux.sv
// Module: forms the perceptron input vector. In cascade mode the oldest
// history bit (MSB) is replaced by the local prediction. Assumes HIST_W >= 2.
module tsel_hist_mux #(
    parameter int HIST_W = 28
) (
    input  logic              casc_en_i,
    input  logic [HIST_W-1:0] ghist_i,
    input  logic              loc_pred_i,
    output logic [HIST_W-1:0] hist_o
);

    // Swap in the local bit at the oldest position when cascading.
    always_comb begin
        hist_o = ghist_i;
        if (casc_en_i) hist_o[HIST_W-1] = loc_pred_i;
    end

endmodule

// File: rtl/tsel_hybrid.sv
// Module: top of the tournament chooser with cascaded history input.
// Selects between perceptron and local predictions using a PC-indexed
// chooser table, builds the perceptron history, and trains the chooser
// from commit data. Assumes the commit side returns the lookup index.
module tsel_hybrid
    import tsel_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [PC_W-1:0]   lk_pc_i,
    input  logic [HIST_W-1:0] ghist_i,
    input  logic              glb_pred_i,
    input  logic              loc_pred_i,
    output logic              final_pred_o,
    output logic [HIST_W-1:0] pcp_hist_o,
    output logic [IDX_W-1:0]  lk_idx_o,
    input  logic              up_valid_i,
    input  logic [IDX_W-1:0]  up_idx_i,
    input  logic              up_glb_pred_i,
    input  logic              up_loc_pred_i,
    input  logic              up_actual_i
);

    logic sel_en;
    logic casc_en;
    logic upd_inc;
    logic upd_dec;
    ctr_t rd_ctr;

    assign sel_en   = mode_i[MODE_SEL_BIT];
    assign casc_en  = mode_i[MODE_CASC_BIT];
    assign lk_idx_o = lk_pc_i[IDX_W-1:0];

    tsel_train u_train (
        .up_glb_pred_i (up_glb_pred_i),
        .up_loc_pred_i (up_loc_pred_i),
        .up_actual_i   (up_actual_i),
        .inc_o         (upd_inc),
        .dec_o         (upd_dec)
    );

    tsel_chooser_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (up_valid_i),
        .wr_idx_i (up_idx_i),
        .inc_i    (upd_inc),
        .dec_i    (upd_dec),
        .rd_idx_i (lk_idx_o),
        .rd_ctr_o (rd_ctr)
    );

    tsel_hist_mux #(.HIST_W(HIST_W)) u_hist (
        .casc_en_i  (casc_en),
        .ghist_i    (ghist_i),
        .loc_pred_i (loc_pred_i),
        .hist_o     (pcp_hist_o)
    );

    // Final choice: chooser decides only when selection is enabled.
    always_comb begin
        if (sel_en && !prefers_glb(rd_ctr)) final_pred_o = loc_pred_i;
        else                                final_pred_o = glb_pred_i;
    end

endmodule

// File: rtl/tsel_hybrid_chk.sv
// Checker: temporal properties of the tournament chooser, bound to the top.
module tsel_hybrid_chk #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 28
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic [PC_W-1:0]   lk_pc_i,
    input logic [HIST_W-1:0] ghist_i,
    input logic              glb_pred_i,
    input logic              loc_pred_i,
    input logic              final_pred_o,
    input logic [HIST_W-1:0] pcp_hist_o,
    input logic [IDX_W-1:0]  lk_idx_o,
    input logic              up_valid_i
);

    // R10
    hist_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[1] |-> pcp_hist_o == ghist_i);

    // R9
    casc_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i[1] |-> (pcp_hist_o[HIST_W-2:0] == ghist_i[HIST_W-2:0])
                      && (pcp_hist_o[HIST_W-1] == loc_pred_i));

    // R11
    glb_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i[0] |-> final_pred_o == glb_pred_i);

    // R2
    agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (glb_pred_i == loc_pred_i) |-> final_pred_o == glb_pred_i);

    // R7
    idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_idx_o == lk_pc_i[IDX_W-1:0]);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(up_valid_i) && $stable(lk_pc_i) && $stable(mode_i)
         && $stable(glb_pred_i) && $stable(loc_pred_i)) |-> $stable(final_pred_o));

endmodule

bind tsel_hybrid tsel_hybrid_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .lk_pc_i      (lk_pc_i),
    .ghist_i      (ghist_i),
    .glb_pred_i   (glb_pred_i),
    .loc_pred_i   (loc_pred_i),
    .final_pred_o (final_pred_o),
    .pcp_hist_o   (pcp_hist_o),
    .lk_idx_o     (lk_idx_o),
    .up_valid_i   (up_valid_i)
);

// File: tb/tb_tsel_hybrid.sv
module tb_tsel_hybrid;

    localparam int PC_W   = 8;
    localparam int IDX_W  = 3;
    localparam int HIST_W = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [1:0]        mode_i;
    logic [PC_W-1:0]   lk_pc_i;
    logic [HIST_W-1:0] ghist_i;
    logic              glb_pred_i;
    logic              loc_pred_i;
    logic              final_pred_o;
    logic [HIST_W-1:0] pcp_hist_o;
    logic [IDX_W-1:0]  lk_idx_o;
    logic              up_valid_i;
    logic [IDX_W-1:0]  up_idx_i;
    logic              up_glb_pred_i;
    logic              up_loc_pred_i;
    logic              up_actual_i;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tsel_hybrid #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .lk_pc_i       (lk_pc_i),
        .ghist_i       (ghist_i),
        .glb_pred_i    (glb_pred_i),
        .loc_pred_i    (loc_pred_i),
        .final_pred_o  (final_pred_o),
        .pcp_hist_o    (pcp_hist_o),
        .lk_idx_o      (lk_idx_o),
        .up_valid_i    (up_valid_i),
        .up_idx_i      (up_idx_i),
        .up_glb_pred_i (up_glb_pred_i),
        .up_loc_pred_i (up_loc_pred_i),
        .up_actual_i   (up_actual_i)
    );

    typedef struct packed {
        logic [1:0] md;
        logic [7:0] pc;
        logic [7:0] gh;
        logic       gp;
        logic       lp;
        logic       uv;
        logic [2:0] ui;
        logic       ug;
        logic       ul;
        logic       ua;
        logic       ef;
        logic [7:0] eh;
    } vec_t;

    localparam int NVEC = 17;
    // Expected final/hist assume chooser entry 5 evolves as noted per row.
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 8'h05, 8'hA5, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R1 ctr=2
        '{2'b01, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5}, // R4 2->1
        '{2'b01, 8'h0D, 8'hA5, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R7 alias ctr=1
        '{2'b01, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 1'b1, 8'hA5}, // R4 1->0
        '{2'b01, 8'h05, 8'hA5, 1'b1, 1'b0, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5}, // R6 stays 0
        '{2'b01, 8'h05, 8'hA5, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5}, // R3 0->1
        '{2'b01, 8'h05, 8'hA5, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b1, 1'b1, 1'b0, 8'hA5}, // R5 both hit
        '{2'b01, 8'h05, 8'hA5, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 1'b0, 1'b0, 8'hA5}, // R5 wrong
        '{2'b10, 8'h05, 8'hDA, 1'b1, 1'b0, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 8'h5A}, // R9 R12 1->2
        '{2'b11, 8'h05, 8'h5A, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hDA}, // R2 2->3
        '{2'b01, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1, 1'b0, 1'b1, 1'b0, 8'hA5}, // R6 stays 3
        '{2'b01, 8'h06, 8'hA5, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5}, // R8 e5 3->2
        '{2'b01, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b1, 3'd5, 1'b0, 1'b1, 1'b1, 1'b0, 8'hA5}, // R13 reads 2
        '{2'b01, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b0, 3'd5, 1'b1, 1'b0, 1'b1, 1'b1, 8'hA5}, // R13 sees 1
        '{2'b00, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5}, // R11 R10
        '{2'b01, 8'h05, 8'hA5, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hA5}, // R8 invalid ignored
        '{2'b11, 8'h05, 8'h5A, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hDA}  // R11 both, ctr=1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mode_i = 2'b01; lk_pc_i = '0; ghist_i = '0;
        glb_pred_i = 1'b0; loc_pred_i = 1'b0;
        up_valid_i = 1'b0; up_idx_i = '0;
        up_glb_pred_i = 1'b0; up_loc_pred_i = 1'b0; up_actual_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        idle_inputs();
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic reset_sweep(input string tag);
        for (int i = 0; i < (1 << IDX_W); i++) begin
            @(negedge clk);
            mode_i = 2'b01; lk_pc_i = PC_W'(i); glb_pred_i = 1'b1; loc_pred_i = 1'b0;
            up_valid_i = 1'b0;
            #1;
            chk(tag, 32'(final_pred_o), 32'd1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        do_reset();

        // R1: every entry starts at the weak-perceptron value
        reset_sweep("R1 reset state");

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            mode_i        = VECS[v].md;
            lk_pc_i       = VECS[v].pc;
            ghist_i       = VECS[v].gh;
            glb_pred_i    = VECS[v].gp;
            loc_pred_i    = VECS[v].lp;
            up_valid_i    = VECS[v].uv;
            up_idx_i      = VECS[v].ui;
            up_glb_pred_i = VECS[v].ug;
            up_loc_pred_i = VECS[v].ul;
            up_actual_i   = VECS[v].ua;
            #1;
            chk($sformatf("R2/R3/R4/R5/R6/R8/R13 final vec%0d", v),
                32'(final_pred_o), 32'(VECS[v].ef));
            chk($sformatf("R9/R10 hist vec%0d", v), 32'(pcp_hist_o), 32'(VECS[v].eh));
            chk($sformatf("R7 index vec%0d", v), 32'(lk_idx_o), 32'(VECS[v].pc[IDX_W-1:0]));
        end

        // R12: training in perceptron-only mode still moves entry 2 (2->1->0)
        @(negedge clk);
        mode_i = 2'b00; up_valid_i = 1'b1; up_idx_i = 3'd2;
        up_glb_pred_i = 1'b0; up_loc_pred_i = 1'b1; up_actual_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        up_valid_i = 1'b0; mode_i = 2'b01; lk_pc_i = 8'h02;
        glb_pred_i = 1'b0; loc_pred_i = 1'b1;
        #1;
        chk("R12 train in mode 00", 32'(final_pred_o), 32'd1);

        // R1: reset returns all entries (5 and 2 are now low) to 2
        do_reset();
        reset_sweep("R1 re-reset");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule